// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-ups

This block is one 8-bit general-purpose I/O port as a small microcontroller's register bus sees it. Each pin carries a direction bit, an output bit and a synchronized pin-input bit. Register-bus strobes, shared by every pin of the port, write or read the direction and output registers, read the pin register, and write the pin register. Writing the pin register toggles output bits. Toward the pad the block drives a per-pin output enable, output level and pull-up enable.

The output bit has a second role. On a pin set as an input, it requests the pull-up. A chip-wide pull-up-disable input cancels every pull-up. The active-low reset clears the direction and output registers asynchronously, so all pins go tri-state even while no clock runs. Pad inputs reach the readable pin register through a level latch and a flip-flop, both timed by the I/O clock. A sleep input forces the synchronizer input low, so a floating pad cannot toggle internal logic.

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low, pad_oe_o, pad_out_o and pad_pu_o are all 0 and the direction and output registers read 0; this takes effect without any clock edge.
- R2: A direction write loads wdata_i into the direction register on the next rising edge. Bit n = 1 sets pad_oe_o[n] = 1 (output) and bit n = 0 sets pad_oe_o[n] = 0 (input).
- R3: An output write loads wdata_i into the output register. pad_out_o[n] equals output bit n when pin n is an output and is 0 when pin n is an input.
- R4: pad_pu_o[n] is 1 exactly when direction bit n is 0, output bit n is 1 and pud_i is 0. A pin set as an output never has its pull-up enabled.
- R5: While pud_i is 1, every bit of pad_pu_o is 0, whatever the registers hold.
- R6: A pin-register write (pin_we_i) inverts each output bit whose wdata_i bit is 1 and leaves the bits where wdata_i is 0 unchanged. If out_we_i is also high in the same cycle, the output write wins and no toggle is applied.
- R7: rdata_o returns the direction register when dir_re_i is high. Otherwise it returns the output register when out_re_i is high. Otherwise it returns the pin register when pin_re_i is high. With no read strobe it returns 0.
- R8: The pin register takes a pad level that is present during the low phase of clk_i at the rising edge that follows. A pad change made just after a rising edge appears in a pin read one clock later, and no change takes more than two clocks.
- R9: While sleep_i is high, the synchronizer input is forced to 0, and the pin register reads 0 from the clock after sleep is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pud_i | input | 1 | Global pull-up disable |
| sleep_i | input | 1 | Sleep control; blocks the pad input |
| dir_we_i | input | 1 | Direction register write strobe |
| dir_re_i | input | 1 | Direction register read strobe |
| out_we_i | input | 1 | Output register write strobe |
| out_re_i | input | 1 | Output register read strobe |
| pin_we_i | input | 1 | Pin register write strobe (toggles output bits) |
| pin_re_i | input | 1 | Pin register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| pad_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin driven level |
| pad_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
The assertions check the following on every cycle: tri-state during reset, the direction and output write effects one edge later, the toggle arithmetic of pin-register writes, that a pull-up never coexists with an output enable or with the global disable, and the zeroing of the pin register under sleep. The bench's scenarios are needed for the rest. These are the read-strobe priority, the asynchronous reset with no clock edge, and the exact sampling window of the latch-plus-flop synchronizer: a change in the high phase is seen one clock later, and a change in the low phase is seen at the next edge. The bench also sweeps all 256 direction patterns against output patterns, with and without the pull-up disable.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned GPIO_W = 8;

  function automatic logic [GPIO_W-1:0] pull_en(input logic [GPIO_W-1:0] dir,
                                                input logic [GPIO_W-1:0] outv,
                                                input logic pud);
    return pud ? '0 : (~dir & outv);
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_we_i,
  input  logic         out_we_i,
  input  logic         pin_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      out_o <= '0;
    end else begin
      if (dir_we_i) dir_o <= wdata_i;
      // plain output write has priority over toggle
      if (out_we_i)      out_o <= wdata_i;
      else if (pin_we_i) out_o <= out_o ^ wdata_i;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] lat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // transparent in the low phase, closed while clk_i is high
    always_latch begin
      if (!clk_i) lat_q[i] <= sleep_i ? 1'b0 : pad_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_o[i] <= 1'b0;
      else         pin_o[i] <= lat_q[i];
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] out_i,
  input  logic         pud_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] pu_o
);
  localparam int unsigned PW = GPIO_W;
  logic [PW-1:0] pu_full;

  always_comb begin
    pu_full = pull_en(PW'(dir_i), PW'(out_i), pud_i);
    oe_o    = dir_i;
    lvl_o   = dir_i & out_i;
    pu_o    = pu_full[W-1:0];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pud_i,
  input  logic         sleep_i,
  input  logic         dir_we_i,
  input  logic         dir_re_i,
  input  logic         out_we_i,
  input  logic         out_re_i,
  input  logic         pin_we_i,
  input  logic         pin_re_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] pad_out_o,
  output logic [W-1:0] pad_pu_o
);
  logic [W-1:0] dir_q, out_q, pin_q;

  gpio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .dir_we_i, .out_we_i, .pin_we_i, .wdata_i,
    .dir_o(dir_q), .out_o(out_q)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk_i, .rst_ni, .sleep_i, .pad_i, .pin_o(pin_q)
  );

  gpio_pad_ctrl #(.W(W)) u_pad (
    .dir_i(dir_q), .out_i(out_q), .pud_i,
    .oe_o(pad_oe_o), .lvl_o(pad_out_o), .pu_o(pad_pu_o)
  );

  always_comb begin
    if (dir_re_i)      rdata_o = dir_q;
    else if (out_re_i) rdata_o = out_q;
    else if (pin_re_i) rdata_o = pin_q;
    else               rdata_o = '0;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         pud_i,
  input logic         sleep_i,
  input logic         dir_we_i,
  input logic         out_we_i,
  input logic         pin_we_i,
  input logic [W-1:0] wdata_i,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] pad_out_o,
  input logic [W-1:0] pad_pu_o,
  input logic [W-1:0] out_q,
  input logic [W-1:0] pin_q
);
  assert_reset_tristate_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (pad_oe_o == '0 && pad_pu_o == '0 && pad_out_o == '0));

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> pad_oe_o == $past(wdata_i));

  assert_drive_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_i |=> pad_out_o == ($past(wdata_i) & pad_oe_o));

  assert_no_pull_on_output_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);

  assert_pud_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pud_i |-> pad_pu_o == '0);

  assert_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_we_i && !out_we_i) |=> out_q == ($past(out_q) ^ $past(wdata_i)));

  assert_sleep_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> pin_q == '0);
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pud_i(pud_i), .sleep_i(sleep_i),
  .dir_we_i(dir_we_i), .out_we_i(out_we_i), .pin_we_i(pin_we_i),
  .wdata_i(wdata_i), .pad_oe_o(pad_oe_o), .pad_out_o(pad_out_o),
  .pad_pu_o(pad_pu_o), .out_q(out_q), .pin_q(pin_q)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pud = 1'b0, sleep = 1'b0;
  logic       dir_we = 1'b0, dir_re = 1'b0, out_we = 1'b0, out_re = 1'b0;
  logic       pin_we = 1'b0, pin_re = 1'b0;
  logic [7:0] wdata = '0, pad = '0;
  logic [7:0] rdata, oe, lvl, pu;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port #(.W(8)) u_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .pud_i(pud), .sleep_i(sleep),
    .dir_we_i(dir_we), .dir_re_i(dir_re), .out_we_i(out_we), .out_re_i(out_re),
    .pin_we_i(pin_we), .pin_re_i(pin_re), .wdata_i(wdata), .rdata_o(rdata),
    .pad_i(pad), .pad_oe_o(oe), .pad_out_o(lvl), .pad_pu_o(pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    dir_we = (sel == 0); out_we = (sel == 1); pin_we = (sel == 2);
    @(negedge clk);
    dir_we = 0; out_we = 0; pin_we = 0;
  endtask

  task automatic rd(input int sel, output logic [7:0] v);
    dir_re = (sel == 0); out_re = (sel == 1); pin_re = (sel == 2);
    #0.5 v = rdata;
    dir_re = 0; out_re = 0; pin_re = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    #1;
    chk("R1 reset oe", oe, 8'h00);
    chk("R1 reset pu", pu, 8'h00);
    rd(0, v); chk("R1 reset dir", v, 8'h00);
    rd(1, v); chk("R1 reset out", v, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5 sweep of direction against output patterns
    for (int d = 0; d < 256; d++) begin
      logic [7:0] o;
      o = 8'((d * 37 + 11) ^ (d >> 3));
      wr(0, 8'(d));
      wr(1, o);
      pud = 1'b0;
      #0.5;
      chk("R2 oe", oe, 8'(d));
      chk("R3 level", lvl, o & 8'(d));
      chk("R4 pull", pu, ~8'(d) & o);
      pud = 1'b1;
      #0.5;
      chk("R5 pud", pu, 8'h00);
      pud = 1'b0;
      rd(0, v); chk("R2 read dir", v, 8'(d));
      rd(1, v); chk("R3 read out", v, o);
    end

    // R6 toggle
    wr(0, 8'h00);
    wr(1, 8'hA5);
    wr(2, 8'h0F);
    rd(1, v); chk("R6 toggle", v, 8'hAA);
    wr(2, 8'h00);
    rd(1, v); chk("R6 zero no change", v, 8'hAA);
    wr(2, 8'hFF);
    rd(1, v); chk("R6 toggle all", v, 8'h55);
    @(negedge clk);
    wdata = 8'h33; out_we = 1; pin_we = 1;
    @(negedge clk);
    out_we = 0; pin_we = 0;
    rd(1, v); chk("R6 out write wins", v, 8'h33);

    // R7 read priority
    wr(0, 8'hC3);
    dir_re = 1; out_re = 1; pin_re = 1; #0.5;
    chk("R7 dir first", rdata, 8'hC3);
    dir_re = 0; #0.5;
    chk("R7 out second", rdata, 8'h33);
    out_re = 0; pin_re = 0; #0.5;
    chk("R7 none", rdata, 8'h00);

    // R8 synchronizer latency
    pad = 8'h00;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    pad = 8'h5C;
    @(negedge clk); rd(2, v); chk("R8 not yet before edge", v, 8'h00);
    @(posedge clk); #1;
    rd(2, v); chk("R8 seen after one clock", v, 8'h5C);
    @(negedge clk); #0.5;
    pad = 8'hE1;
    @(posedge clk); #1;
    rd(2, v); chk("R8 low-phase change next edge", v, 8'hE1);

    // R9 sleep
    @(negedge clk); sleep = 1'b1;
    @(posedge clk); #1;
    rd(2, v); chk("R9 sleep zero", v, 8'h00);
    @(negedge clk); sleep = 1'b0;
    @(posedge clk); #1;
    rd(2, v); chk("R9 wake resample", v, 8'hE1);

    // R1 asynchronous reset mid-cycle
    wr(0, 8'h0F);
    wr(1, 8'hFF);
    #0.5;
    chk("R1 pre oe", oe, 8'h0F);
    chk("R1 pre pu", pu, 8'hF0);
    rst_n = 1'b0;
    #0.5;
    chk("R1 async oe", oe, 8'h00);
    chk("R1 async pu", pu, 8'h00);
    chk("R1 async lvl", lvl, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule